// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a set of external interrupt lines and turns them into one interrupt request for a processor. Each line is first brought into the local clock domain. It is then sensed in one of four ways: rising edge, falling edge, active-high level or active-low level. A detected event sets a sticky pending bit for that line. The pending bits are ANDed with a per-line enable mask, and the request output is raised whenever any enabled line is pending. A separate flag lets software signal non-maskable interrupts.

Software reaches the block through a plain register port made of a byte address, a write strobe, write data and combinational read data. Enables are never written directly. Separate write-one-to-set and write-one-to-clear registers change them, and a third write-one register acknowledges pending bits. The parameter `NUM_LINES` sets how many lines exist. Bits above that count ignore writes and read as zero, so software can find the line count by writing all ones to the sense-mode register and reading it back. The port carries no streamed data, so it has no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high, and a read returns data in the same cycle.

Top module: `xirq_ctrl`

## Requirements
- R1: A write to byte address 0x00 sets every enable bit whose write-data bit is 1. A write to 0x04 clears every enable bit whose write-data bit is 1. Zero bits leave enables unchanged. Address 0x08 reads the enables back.
- R2: A write to 0x10 clears each pending bit written with 1 and leaves the others alone. Address 0x0C reads the pending bits.
- R3: Address 0x14 holds the sense-mode bits, where 1 selects level and 0 selects edge. Address 0x18 holds the edge-polarity bits, where 1 selects rising and 0 selects falling.
- R4: Address 0x1C holds the level-polarity bits, where 1 selects active high and 0 selects active low. In level mode the pending bit is set again on every cycle the active level is present, so an acknowledge does not stick while the level persists.
- R5: In edge mode a pending bit stays set until it is acknowledged.
- R6: Bits at and above `NUM_LINES` ignore writes and read as 0 in every register. Writing all ones to 0x14 therefore reads back as 2^NUM_LINES - 1.
- R7: `irq_out` is high exactly when some line is both pending and enabled.
- R8: Bit 0 of the register at 0x24 drives `nmi_en_out`.
- R9: After reset all enable, pending, mode, edge, level and NMI bits are 0, and `irq_out` is low.
- R10: A change on a line input reaches the pending register at the third rising clock edge after the change. Two edges are spent in the synchroniser, and the pending bit is updated on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | NUM_LINES | External interrupt lines (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Interrupt request to the processor |
| nmi_en_out | output | 1 | Non-maskable interrupt enable flag |

## Verification
The bench builds the block with `NUM_LINES = 6`. This leaves the upper 26 bits of every register unimplemented, so the discovery readback (0x3F) and the zero read-back of the missing bits can both be observed. All four sense settings are exercised on line 0. The latency, stickiness and level-persistence tests use further lines, which checks that lines do not interfere with one another.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;

  // word index = byte address / 4
  typedef enum logic [3:0] {
    RI_EN_SET = 4'd0,
    RI_EN_CLR = 4'd1,
    RI_MASK   = 4'd2,
    RI_STATUS = 4'd3,
    RI_CLEAR  = 4'd4,
    RI_MODE   = 4'd5,
    RI_EDGE   = 4'd6,
    RI_LEVEL  = 4'd7,
    RI_NMI    = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sync_in,
  input  logic [LINES-1:0] mode_lvl,
  input  logic [LINES-1:0] pol_rise,
  input  logic [LINES-1:0] pol_high,
  output logic [LINES-1:0] hit
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic rise, fall, lvl_hit, edg_hit;
    assign rise    = sync_in[g] & ~prev_q[g];
    assign fall    = ~sync_in[g] & prev_q[g];
    assign lvl_hit = (sync_in[g] == pol_high[g]);
    assign edg_hit = pol_rise[g] ? rise : fall;
    assign hit[g]  = mode_lvl[g] ? lvl_hit : edg_hit;
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [LINES-1:0]  hit,
  output logic [REG_W-1:0]  rdata,
  output logic [LINES-1:0]  mode_o,
  output logic [LINES-1:0]  edge_o,
  output logic [LINES-1:0]  level_o,
  output logic [LINES-1:0]  pend_o,
  output logic              nmi_o
);
  logic [3:0]       widx;
  logic [LINES-1:0] wbits, mask_q, status_q, clr_vec;
  logic [LINES-1:0] mode_q, edge_q, level_q;
  logic             nmi_q;

  assign widx    = addr[ADDR_W-1:2];
  assign wbits   = wdata[LINES-1:0];
  assign clr_vec = (wr_en && widx == RI_CLEAR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; mode_q <= '0; edge_q <= '0; level_q <= '0; nmi_q <= 1'b0;
    end else if (wr_en) begin
      case (widx)
        RI_EN_SET: mask_q  <= mask_q | wbits;
        RI_EN_CLR: mask_q  <= mask_q & ~wbits;
        RI_MODE:   mode_q  <= wbits;
        RI_EDGE:   edge_q  <= wbits;
        RI_LEVEL:  level_q <= wbits;
        RI_NMI:    nmi_q   <= wdata[0];
        default: ;
      endcase
    end
  end

  // a new event on the same cycle as an acknowledge keeps the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | hit;
  end

  always_comb begin
    rdata = '0;
    case (widx)
      RI_MASK:   rdata[LINES-1:0] = mask_q;
      RI_STATUS: rdata[LINES-1:0] = status_q;
      RI_MODE:   rdata[LINES-1:0] = mode_q;
      RI_EDGE:   rdata[LINES-1:0] = edge_q;
      RI_LEVEL:  rdata[LINES-1:0] = level_q;
      RI_NMI:    rdata[0]         = nmi_q;
      default:   rdata = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign edge_o  = edge_q;
  assign level_o = level_q;
  assign pend_o  = status_q & mask_q;
  assign nmi_o   = nmi_q;

  p_mask_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == RI_EN_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == RI_EN_CLR) |=> ((mask_q & $past(wbits)) == '0));
  p_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == RI_CLEAR) |=> ((status_q & $past(wbits & ~hit)) == '0));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));
  p_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == RI_NMI) |=> (nmi_q == $past(wdata[0])));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 wr_en,
  input  logic [5:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 irq_out,
  output logic                 nmi_en_out
);
  logic [NUM_LINES-1:0] sync_q, hit, mode_v, edge_v, level_v, pend;

  initial begin
    if (NUM_LINES < 1 || NUM_LINES > REG_W) $error("NUM_LINES out of range");
  end

  xirq_sync #(.W(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(sync_q)
  );

  xirq_sense #(.LINES(NUM_LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_q),
    .mode_lvl(mode_v), .pol_rise(edge_v), .pol_high(level_v), .hit(hit)
  );

  xirq_regs #(.LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(hit), .rdata(rdata), .mode_o(mode_v), .edge_o(edge_v),
    .level_o(level_v), .pend_o(pend), .nmi_o(nmi_en_out)
  );

  assign irq_out = |pend;

  p_no_irq_in_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !irq_out);
endmodule

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
  localparam int N = 6;
  localparam logic [31:0] IMPL = 32'h3F;

  // fields: [5] mode [4] edge [3] level [2] start value [1] end value [0] expected pending
  localparam logic [5:0] VEC [8] = '{
    6'b010011, 6'b010100, 6'b000101, 6'b000010,
    6'b101111, 6'b101000, 6'b100001, 6'b100110
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [N-1:0] line_in = '0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata, rv;
  logic irq_out, nmi_en_out;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xirq_ctrl #(.NUM_LINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .nmi_en_out(nmi_en_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; @(negedge clk);
    // R9 reset state
    rd(6'h08, rv); chk("R9 mask", rv, 0);
    rd(6'h0C, rv); chk("R9 status", rv, 0);
    rd(6'h14, rv); chk("R9 mode", rv, 0);
    rd(6'h24, rv); chk("R9 nmi", rv, 0);
    chk("R9 irq", {31'b0, irq_out}, 0);
    // R6 discovery
    wr(6'h14, 32'hFFFF_FFFF); rd(6'h14, rv); chk("R6 mode readback", rv, IMPL);
    wr(6'h14, 32'h0); cyc(4); wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h0C, rv); chk("R6 status cleared", rv, 0);
    // R1 enables
    wr(6'h00, 32'hFFFF_FF05); rd(6'h08, rv); chk("R1 set", rv, 32'h05);
    wr(6'h00, 32'h02); rd(6'h08, rv); chk("R1 set keeps", rv, 32'h07);
    wr(6'h04, 32'h01); rd(6'h08, rv); chk("R1 clear", rv, 32'h06);
    // R3 R4 sense table on line 0
    for (int i = 0; i < 8; i++) begin
      wr(6'h14, {31'b0, VEC[i][5]});
      wr(6'h18, {31'b0, VEC[i][4]});
      wr(6'h1C, {31'b0, VEC[i][3]});
      line_in[0] = VEC[i][2]; cyc(4);
      wr(6'h10, 32'h1);
      line_in[0] = VEC[i][1]; cyc(4);
      rd(6'h0C, rv);
      chk($sformatf("R3/R4 sense vector %0d", i), rv & 32'h1, {31'b0, VEC[i][0]});
    end
    wr(6'h14, 32'h0); wr(6'h18, 32'h0); wr(6'h1C, 32'h0);
    line_in[0] = 1'b0; cyc(4); wr(6'h10, 32'h3F);
    // R10 latency, rising edge on line 1
    wr(6'h18, 32'h02);
    line_in[1] = 1'b1;
    cyc(2); rd(6'h0C, rv); chk("R10 after two edges", rv & 32'h2, 0);
    cyc(1); rd(6'h0C, rv); chk("R10 after three edges", rv & 32'h2, 32'h2);
    // R5 sticky
    line_in[1] = 1'b0; cyc(10); rd(6'h0C, rv); chk("R5 sticky", rv & 32'h2, 32'h2);
    // R7 irq from pending and enable
    chk("R7 irq on", {31'b0, irq_out}, 1);
    wr(6'h04, 32'h02); chk("R7 irq masked", {31'b0, irq_out}, 0);
    // R2 acknowledge
    wr(6'h10, 32'h0); rd(6'h0C, rv); chk("R2 zero write ignored", rv, 32'h2);
    wr(6'h10, 32'h2); rd(6'h0C, rv); chk("R2 ack", rv, 0);
    // R4 level persistence on line 2
    wr(6'h14, 32'h04); wr(6'h1C, 32'h04);
    line_in[2] = 1'b1; cyc(4);
    wr(6'h10, 32'h4); rd(6'h0C, rv); chk("R4 level re-sets", rv & 32'h4, 32'h4);
    line_in[2] = 1'b0; cyc(4);
    wr(6'h10, 32'h4); rd(6'h0C, rv); chk("R4 inactive stays clear", rv & 32'h4, 0);
    // R8 nmi flag
    wr(6'h24, 32'h1); chk("R8 nmi on", {31'b0, nmi_en_out}, 1);
    wr(6'h24, 32'h2); chk("R8 nmi off", {31'b0, nmi_en_out}, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule